// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block sits between a simple request/acknowledge host port and an external asynchronous static RAM of 256K sixteen-bit words with separate low-byte and high-byte enables. The host presents an 18-bit word address, a write flag, sixteen bits of write data and a two-bit byte mask, raises `req_i` for one cycle, and waits for a one-cycle `ack_o`. For a read, the word is on `rdata_o` in the acknowledge cycle.

All memory strobes are active low and are derived from a registered state machine. Each phase is held for a whole number of clock cycles. That number is the nanosecond minimum of the memory divided by the clock period parameter, rounded up. A write is ended by raising the write strobe while address, chip enable, byte enables and data stay put. The data bus is split into an output value, an output enable and an input value for the pad ring. The controller never enables its driver while the memory output enable is active. After a read it waits out the memory's output-off time before it drives.

Top module: `sram_ctl_top`

## Requirements
- R1: While `rst_ni` is low and after reset until the first request, `mem_ce_no`, `mem_oe_no`, `mem_we_no` and both `mem_bs_no` bits are 1, `dq_oe_o` is 0 and `ack_o` is 0.
- R2: A read holds `mem_ce_no` and `mem_oe_no` low for exactly RD = ceil(45 ns / CLK_NS) consecutive cycles, starting the cycle after the accepting edge.
- R3: The read word is sampled from `dq_i` at the edge that ends the access. It appears on `rdata_o` with `ack_o` high in the cycle after that edge, which is RD edges after the accepting edge.
- R4: A write has three phases. It first holds one cycle with chip enable and byte strobes low, the driver on and WE high. It then holds WE low for WP = max(ceil(35/CLK_NS), ceil(25/CLK_NS)) cycles. It ends with REC = max(1, ceil(45/CLK_NS) - 1 - WP) cycles with WE high, chip enable, byte strobes and the driver still on. `ack_o` is high in the last of those cycles, WP+REC edges after the accepting edge.
- R5: `be_i[0]` selects the low byte (`mem_bs_no[0]`, data bits 7:0) and `be_i[1]` the high byte (`mem_bs_no[1]`, bits 15:8). A cleared mask bit keeps its strobe high, and that byte of memory is left unchanged.
- R6: `dq_oe_o` is never 1 while `mem_oe_no` is 0. `mem_we_no` is low only while `mem_ce_no` is low and `dq_oe_o` is 1.
- R7: A write whose previous operation was a read first waits TA = ceil(18/CLK_NS) cycles with all strobes inactive. Its acknowledge is delayed by TA cycles.
- R8: A write whose previous operation was a write, or the first write after reset, starts its setup phase directly after the accepting edge.
- R9: `req_i` is only accepted in the idle cycle. A request raised while an operation is in progress gets no acknowledge and changes no memory word.
- R10: `ack_o` is high for exactly one cycle per accepted request.
- R11: `mem_addr_o` is stable while `mem_ce_no` is low, and `dq_o` is stable while `dq_oe_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe, sampled in idle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| be_i | input | 2 | Byte mask, bit 0 = low byte |
| ack_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 16 | Read word, valid with ack of a read |
| mem_addr_o | output | 18 | Memory address |
| mem_ce_no | output | 1 | Memory chip enable, active low |
| mem_oe_no | output | 1 | Memory output enable, active low |
| mem_we_no | output | 1 | Memory write enable, active low |
| mem_bs_no | output | 2 | Byte strobes, active low, bit 0 = low byte |
| dq_o | output | 16 | Data bus value to drive |
| dq_oe_o | output | 1 | Data bus driver enable |
| dq_i | input | 16 | Data bus value from the pad |

## Verification
With the bench clock of 5 ns, the due times are fixed. A read acknowledges 9 edges after the accepting edge. A write acknowledges 8 edges after it, or 12 when it follows a read. The bench works out the due cycle when it raises a request and compares `ack_o` against it at every falling edge. The read word is checked in that same cycle. A memory model updates on falling edges and returns junk until the output enable has been low for the full access. It also counts each WE pulse, data-stable window, address-stable window and output-off gap, and fails any that is short. Memory contents are checked only through later reads at the ports.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_DONE,
    ST_TURN,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_REC
  } ctl_state_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int W = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         done_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R2 R4: phase counter steps down by one per cycle until it reaches zero
  a_r4_timer_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
  import sram_ctl_pkg::*;
#(
  parameter int RD_CYC  = 5,
  parameter int WP_CYC  = 4,
  parameter int REC_CYC = 1,
  parameter int TA_CYC  = 2,
  parameter int CW      = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic          done_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          accept_o,
  output logic          capture_o,
  output logic          ack_o,
  output logic          ce_o,
  output logic          oe_o,
  output logic          we_o,
  output logic          bytes_o,
  output logic          drive_o
);

  ctl_state_e state_q, state_d;
  logic       last_rd_q;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        load_o = 1'b1;
        if (!we_i) begin
          state_d    = ST_RD_ACC;
          load_val_o = CW'(RD_CYC - 1);
        end else if (last_rd_q) begin
          state_d    = ST_TURN;
          load_val_o = CW'(TA_CYC - 1);
        end else begin
          state_d    = ST_WR_SETUP;
        end
      end
      ST_RD_ACC:  if (done_i) state_d = ST_RD_DONE;
      ST_RD_DONE: state_d = ST_IDLE;
      ST_TURN:    if (done_i) begin
        state_d = ST_WR_SETUP;
        load_o  = 1'b1;
      end
      ST_WR_SETUP: if (done_i) begin
        state_d    = ST_WR_PULSE;
        load_o     = 1'b1;
        load_val_o = CW'(WP_CYC - 1);
      end
      ST_WR_PULSE: if (done_i) begin
        state_d    = ST_WR_REC;
        load_o     = 1'b1;
        load_val_o = CW'(REC_CYC - 1);
      end
      ST_WR_REC:  if (done_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      last_rd_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_RD_DONE)                last_rd_q <= 1'b1;
      else if (state_q == ST_IDLE && req_i && we_i) last_rd_q <= 1'b0;
    end
  end

  assign accept_o  = (state_q == ST_IDLE) && req_i;
  assign capture_o = (state_q == ST_RD_ACC) && done_i;
  assign ack_o     = (state_q == ST_RD_DONE) || ((state_q == ST_WR_REC) && done_i);

  always_comb begin
    ce_o    = 1'b0;
    oe_o    = 1'b0;
    we_o    = 1'b0;
    bytes_o = 1'b0;
    drive_o = 1'b0;
    unique case (state_q)
      ST_RD_ACC: begin
        ce_o = 1'b1; oe_o = 1'b1; bytes_o = 1'b1;
      end
      ST_WR_SETUP, ST_WR_REC: begin
        ce_o = 1'b1; bytes_o = 1'b1; drive_o = 1'b1;
      end
      ST_WR_PULSE: begin
        ce_o = 1'b1; bytes_o = 1'b1; we_o = 1'b1; drive_o = 1'b1;
      end
      default: ;
    endcase
  end

  // window counters for the assertions below
  int oe_win_q, we_win_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oe_win_q <= 0;
      we_win_q <= 0;
    end else begin
      oe_win_q <= oe_o ? oe_win_q + 1 : 0;
      we_win_q <= we_o ? we_win_q + 1 : 0;
    end
  end

  // R2: output enable active for exactly the read access length
  a_r2_read_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(oe_o) |-> (oe_win_q == RD_CYC));

  // R4: write strobe active for exactly the pulse length
  a_r4_we_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(we_o) |-> (we_win_q == WP_CYC));

  // R10: acknowledge is a single-cycle pulse
  a_r10_ack_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R9: no acceptance outside idle
  a_r9_accept_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (state_q != ST_IDLE));

endmodule

// File: rtl/sram_ctl_datapath.sv
module sram_ctl_datapath #(
  parameter int AW = 18,
  parameter int DW = 16,
  parameter int BW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          accept_i,
  input  logic          capture_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [BW-1:0] be_i,
  input  logic          ce_i,
  input  logic          oe_i,
  input  logic          we_i,
  input  logic          bytes_i,
  input  logic          drive_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] rdata_o,
  output logic [AW-1:0] mem_addr_o,
  output logic          mem_ce_no,
  output logic          mem_oe_no,
  output logic          mem_we_no,
  output logic [BW-1:0] mem_bs_no,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic [BW-1:0] be_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept_i) begin
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
      be_q    <= be_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        rdata_q <= '0;
    else if (capture_i) rdata_q <= dq_i;
  end

  for (genvar b = 0; b < BW; b++) begin : g_bs
    assign mem_bs_no[b] = ~(bytes_i & be_q[b]);
  end

  assign rdata_o    = rdata_q;
  assign mem_addr_o = addr_q;
  assign mem_ce_no  = ~ce_i;
  assign mem_oe_no  = ~oe_i;
  assign mem_we_no  = ~we_i;
  assign dq_o       = wdata_q;
  assign dq_oe_o    = drive_i;

  // R6: driver never on while the memory outputs are enabled
  a_r6_no_contention: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> mem_oe_no);

  // R6: write strobe only inside chip enable with data driven
  a_r6_we_qualified: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce_no && dq_oe_o));

  // R11: address held while the chip is enabled
  a_r11_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> $stable(mem_addr_o));

  // R11: driven data held while the driver is on
  a_r11_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dq_oe_o && $past(dq_oe_o)) |-> $stable(dq_o));

endmodule

// File: rtl/sram_ctl_top.sv
module sram_ctl_top
  import sram_ctl_pkg::*;
#(
  parameter int CLK_NS   = 10,
  parameter int T_RC_NS  = 45,
  parameter int T_WC_NS  = 45,
  parameter int T_PWE_NS = 35,
  parameter int T_SD_NS  = 25,
  parameter int T_HZ_NS  = 18,
  parameter int AW       = 18,
  parameter int DW       = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [DW/8-1:0]   be_i,
  output logic              ack_o,
  output logic [DW-1:0]     rdata_o,
  output logic [AW-1:0]     mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_oe_no,
  output logic              mem_we_no,
  output logic [DW/8-1:0]   mem_bs_no,
  output logic [DW-1:0]     dq_o,
  output logic              dq_oe_o,
  input  logic [DW-1:0]     dq_i
);

  localparam int BW      = DW / 8;
  localparam int RD_CYC  = ceil_div(T_RC_NS, CLK_NS);
  localparam int WP_CYC  = max2(ceil_div(T_PWE_NS, CLK_NS), ceil_div(T_SD_NS, CLK_NS));
  localparam int REC_CYC = max2(1, ceil_div(T_WC_NS, CLK_NS) - 1 - WP_CYC);
  localparam int TA_CYC  = max2(1, ceil_div(T_HZ_NS, CLK_NS));
  localparam int MAX_CYC = max2(max2(RD_CYC, WP_CYC), max2(REC_CYC, TA_CYC));
  localparam int CW      = max2(1, $clog2(MAX_CYC + 1));

  logic          load, done, accept, capture;
  logic [CW-1:0] load_val;
  logic          ce, oe, we, bytes, drive;

  sram_phase_timer #(.W(CW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (load_val),
    .done_o     (done)
  );

  sram_ctl_fsm #(
    .RD_CYC  (RD_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC),
    .TA_CYC  (TA_CYC),
    .CW      (CW)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .we_i       (we_i),
    .done_i     (done),
    .load_o     (load),
    .load_val_o (load_val),
    .accept_o   (accept),
    .capture_o  (capture),
    .ack_o      (ack_o),
    .ce_o       (ce),
    .oe_o       (oe),
    .we_o       (we),
    .bytes_o    (bytes),
    .drive_o    (drive)
  );

  sram_ctl_datapath #(.AW(AW), .DW(DW), .BW(BW)) u_dp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .capture_i  (capture),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .be_i       (be_i),
    .ce_i       (ce),
    .oe_i       (oe),
    .we_i       (we),
    .bytes_i    (bytes),
    .drive_i    (drive),
    .dq_i       (dq_i),
    .rdata_o    (rdata_o),
    .mem_addr_o (mem_addr_o),
    .mem_ce_no  (mem_ce_no),
    .mem_oe_no  (mem_oe_no),
    .mem_we_no  (mem_we_no),
    .mem_bs_no  (mem_bs_no),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o)
  );

  // R1: strobes inactive and bus released whenever the chip is not enabled
  a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_ce_no |-> (mem_oe_no && mem_we_no && !dq_oe_o && (&mem_bs_no)));

endmodule

// File: tb/tb_sram_ctl_top.sv
`timescale 1ns/1ps
module tb_sram_ctl_top;

  localparam int CLK_NS = 5;
  localparam int RD     = (45 + CLK_NS - 1) / CLK_NS;
  localparam int WPE    = (35 + CLK_NS - 1) / CLK_NS;
  localparam int WSD    = (25 + CLK_NS - 1) / CLK_NS;
  localparam int WP     = (WPE > WSD) ? WPE : WSD;
  localparam int WCC    = (45 + CLK_NS - 1) / CLK_NS;
  localparam int REC    = ((WCC - 1 - WP) > 1) ? (WCC - 1 - WP) : 1;
  localparam int TA     = (18 + CLK_NS - 1) / CLK_NS;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic        ack_o, mem_ce_no, mem_oe_no, mem_we_no, dq_oe_o;
  logic [15:0] rdata_o, dq_o, dq_i;
  logic [17:0] mem_addr_o;
  logic [1:0]  mem_bs_no;

  always #2.5 clk = ~clk;

  sram_ctl_top #(.CLK_NS(CLK_NS)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .be_i(be), .ack_o(ack_o), .rdata_o(rdata_o),
    .mem_addr_o(mem_addr_o), .mem_ce_no(mem_ce_no), .mem_oe_no(mem_oe_no),
    .mem_we_no(mem_we_no), .mem_bs_no(mem_bs_no), .dq_o(dq_o),
    .dq_oe_o(dq_oe_o), .dq_i(dq_i)
  );

  int    n_cmp = 0, n_bad = 0;
  int    cyc = 0, ack_due = -1;
  bit    done_flag = 0, prev_rd = 0;
  string cur_tag = "R10";
  logic [1:0]  exp_be = '0;
  logic [15:0] mmem [64];
  logic [15:0] shadow [64];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // memory model
  int          rd_cnt = 0, since_oe = 100, we_cnt = 0, ds_cnt = 0, as_cnt = 0;
  int          we_len = 0, ds_at_we = 0, as_at_we = 0;
  bit          we_low_prev = 0, oe_low_prev = 0, drv_prev = 0;
  logic [15:0] dq_prev = '0;
  logic [17:0] addr_prev = '0;
  logic [1:0]  bs_at_we = '1;
  logic        m_drive;

  always_comb begin
    m_drive = !mem_ce_no && !mem_oe_no && mem_we_no;
    if (m_drive && rd_cnt >= RD) begin
      dq_i[7:0]  = mem_bs_no[0] ? 8'hEE : mmem[mem_addr_o[5:0]][7:0];
      dq_i[15:8] = mem_bs_no[1] ? 8'hEE : mmem[mem_addr_o[5:0]][15:8];
    end else begin
      dq_i = 16'hDEAD;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (m_drive && dq_oe_o) chk(0, "R6 bus contention", 1, 0);
    if (dq_oe_o && !drv_prev && prev_rd_gap_check()) chk(since_oe >= TA, "R7 turnaround gap", since_oe, TA);
    if (!mem_oe_no) since_oe = 0; else if (since_oe < 100) since_oe++;
    if (mem_oe_no && oe_low_prev) chk(rd_cnt == RD, "R2 read window", rd_cnt, RD);
    rd_cnt = (!mem_ce_no && !mem_oe_no) ? rd_cnt + 1 : 0;
    oe_low_prev = !mem_oe_no;
    ds_cnt = (dq_oe_o && drv_prev && dq_o == dq_prev) ? ds_cnt + 1 : (dq_oe_o ? 1 : 0);
    as_cnt = (!mem_ce_no && mem_addr_o == addr_prev) ? as_cnt + 1 : (!mem_ce_no ? 1 : 0);
    if (!mem_we_no) begin
      we_cnt++;
      ds_at_we = ds_cnt; as_at_we = as_cnt; bs_at_we = mem_bs_no; we_len = we_cnt;
    end else begin
      we_cnt = 0;
    end
    if (mem_we_no && we_low_prev) begin
      chk(we_len == WP, "R4 WE pulse length", we_len, WP);
      chk(ds_at_we >= WSD, "R11 data setup", ds_at_we, WSD);
      chk(as_at_we >= WPE, "R11 address setup", as_at_we, WPE);
      chk(!mem_ce_no, "R4 chip enable held past WE", mem_ce_no, 0);
      chk(bs_at_we == ~exp_be, "R5 byte strobes", bs_at_we, ~exp_be);
      if (!bs_at_we[0]) mmem[mem_addr_o[5:0]][7:0]  = dq_o[7:0];
      if (!bs_at_we[1]) mmem[mem_addr_o[5:0]][15:8] = dq_o[15:8];
    end
    we_low_prev = !mem_we_no;
    drv_prev = dq_oe_o;
    dq_prev = dq_o;
    addr_prev = mem_addr_o;
  end

  function automatic bit prev_rd_gap_check();
    return prev_rd;
  endfunction

  // every-cycle acknowledge comparison against the due cycle
  always @(negedge clk) if (rst_n && !done_flag)
    chk(ack_o == (cyc == ack_due), cur_tag, ack_o, (cyc == ack_due));

  task automatic do_op(input bit wr, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m, input bit stray, input string tag);
    int lat;
    @(negedge clk);
    lat = wr ? (WP + REC + (prev_rd ? TA : 0)) : RD;
    ack_due = cyc + 1 + lat;
    cur_tag = {tag, " R10 ack timing"};
    exp_be = m;
    req = 1; we = wr; addr = a; wdata = d; be = m;
    @(negedge clk);
    req = 0;
    if (stray) begin
      repeat (2) @(negedge clk);
      req = 1; we = 1; addr = a + 1; wdata = ~d; be = 2'b11;
      @(negedge clk);
      req = 0;
    end
    while (cyc != ack_due) @(negedge clk);
    if (!wr) chk(rdata_o == shadow[a[5:0]], {tag, " R3 read data"}, rdata_o, shadow[a[5:0]]);
    else begin
      if (m[0]) shadow[a[5:0]][7:0]  = d[7:0];
      if (m[1]) shadow[a[5:0]][15:8] = d[15:8];
    end
    @(negedge clk);
    prev_rd = !wr;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      mmem[i]   = 16'(i * 16'h0101) ^ 16'h5A00;
      shadow[i] = 16'(i * 16'h0101) ^ 16'h5A00;
    end
    repeat (3) @(negedge clk);
    chk({mem_ce_no, mem_oe_no, mem_we_no, mem_bs_no, dq_oe_o, ack_o} == 7'b1111100,
        "R1 strobes in reset", {mem_ce_no, mem_oe_no, mem_we_no, mem_bs_no, dq_oe_o, ack_o}, 7'b1111100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk({mem_ce_no, mem_oe_no, mem_we_no, mem_bs_no, dq_oe_o, ack_o} == 7'b1111100,
        "R1 strobes after reset", {mem_ce_no, mem_oe_no, mem_we_no, mem_bs_no, dq_oe_o, ack_o}, 7'b1111100);

    do_op(1, 18'd3, 16'h1234, 2'b11, 0, "R4");
    do_op(1, 18'd4, 16'hABCD, 2'b11, 0, "R8");
    do_op(0, 18'd3, 16'h0, 2'b11, 0, "R2");
    do_op(1, 18'd3, 16'h77FF, 2'b01, 0, "R7");
    do_op(0, 18'd3, 16'h0, 2'b11, 0, "R5");
    do_op(1, 18'd4, 16'h5500, 2'b10, 0, "R5");
    do_op(0, 18'd4, 16'h0, 2'b11, 0, "R5");
    do_op(1, 18'd8, 16'hC3C3, 2'b11, 1, "R9");
    do_op(0, 18'd9, 16'h0, 2'b11, 0, "R9");
    do_op(0, 18'd8, 16'h0, 2'b11, 0, "R9");
    do_op(1, 18'h3FFFF, 16'hF00D, 2'b11, 0, "R7");
    do_op(0, 18'h3FFFF, 16'h0, 2'b11, 0, "R3");
    do_op(1, 18'd10, 16'h9999, 2'b00, 0, "R5");
    do_op(0, 18'd10, 16'h0, 2'b11, 0, "R5");
    do_op(0, 18'd12, 16'h0, 2'b11, 0, "R3");
    repeat (4) @(negedge clk);
    chk({mem_ce_no, dq_oe_o, ack_o} == 3'b100, "R1 quiet after traffic",
        {mem_ce_no, dq_oe_o, ack_o}, 3'b100);
    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_cmp++; n_bad++;
      $display("FAIL watchdog R10 actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule